// File: doc/BRIEF.md
# Multiphase Hysteretic Phase-Steering Controller

This block is the digital decision core of an interleaved multi-rail buck regulator with N phases (four by default). It receives an already digitised output-voltage code and one current code per phase, each set qualified by a sample strobe. It compares the voltage numerically against four programmable thresholds and drives a high-side and a low-side gate enable for every phase. Dead-time insertion, ADC capture and start-up ramping are handled elsewhere.

Two thresholds form the inner band. When the voltage drops below the lower inner threshold, one on-pulse starts. It is steered to the phase that currently carries the least current, found by a balanced tree of pairwise comparisons. That phase keeps the pulse until the voltage climbs above the upper inner threshold, so only one high-side switch conducts at a time. Two outer thresholds form a wider band that catches large transients. Below the outer floor every high-side switch is forced on. Above the outer ceiling every high-side switch is forced off.

Top module: `hyst_phase_steer`

## Requirements
- R1: A synchronous active-high reset clears every high-side enable, sets every low-side enable, and loads the thresholds with their defaults: outer floor 2028, inner floor 2038, inner ceiling 2058, outer ceiling 2068.
- R2: Suppose no pulse is active and a valid sample lies at or above the outer floor but strictly below the inner floor. On the next clock exactly one high-side enable is then set, on the phase whose current code is smallest. Phase k's current sits at bits [k*IW +: IW] of the current bus.
- R3: When several phases share the smallest current, the one with the lowest index is chosen.
- R4: Once a pulse has started, its phase is held regardless of later current samples. This holds for samples inside the inner band, for samples equal to its limits, and for further samples below the inner floor.
- R5: A valid sample strictly above the inner ceiling turns all high-side enables off and all low-side enables on at the next clock.
- R6: A valid sample strictly below the outer floor turns all high-side enables on and all low-side enables off at the next clock. This check has priority over every other check.
- R7: A valid sample strictly above the outer ceiling turns all high-side enables off at the next clock.
- R8: For every phase and every cycle, the low-side enable is the complement of the high-side enable.
- R9: Cycles without the sample strobe leave all enables unchanged, whatever the voltage and current inputs show.
- R10: A threshold write updates the threshold chosen by the select code: 0 outer floor, 1 inner floor, 2 inner ceiling, 3 outer ceiling. The new value is used from the following cycle. A sample in the same cycle is compared against the old value.
- R11: After a forced all-on, samples inside the inner band keep all phases on. A later sample between the outer and inner floors replaces the all-on state with a single pulse on the least-loaded phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Qualifies the voltage and current samples of this cycle |
| vout | input | VW | Output-voltage code, unsigned |
| iph | input | NPH*IW | Phase current codes, phase k at [k*IW +: IW] |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Threshold select: 0 outer floor, 1 inner floor, 2 inner ceiling, 3 outer ceiling |
| cfg_data | input | VW | Threshold value to write |
| hs_en | output | NPH | High-side gate enables, registered |
| ls_en | output | NPH | Low-side gate enables, registered |

## Verification
The bench aims at samples that land exactly on each threshold. A design that used inclusive comparisons would start or end pulses one code early. It also uses equal-current ties: a tree that preferred the right branch would send the pulse to a higher-numbered phase. Current changes in the middle of a pulse catch a design that re-selects the phase on every sample, since that would hop the on-time between phases. Writes issued together with a sample, and the exit from the all-on state, expose stale-threshold bugs and a controller that stays latched in the transient state.

// File: rtl/hps_pkg.sv
package hps_pkg;
  typedef enum logic [1:0] {
    M_OFF = 2'd0,
    M_ONE = 2'd1,
    M_ALL = 2'd2
  } mode_t;

  localparam int SEL_OUT_LO = 0;
  localparam int SEL_IN_LO  = 1;
  localparam int SEL_IN_HI  = 2;
  localparam int SEL_OUT_HI = 3;
endpackage

// File: rtl/hps_limits.sv
module hps_limits #(
  parameter int VW      = 12,
  parameter int DEF_OLO = 2028,
  parameter int DEF_ILO = 2038,
  parameter int DEF_IHI = 2058,
  parameter int DEF_OHI = 2068
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [VW-1:0] data,
  output logic [VW-1:0] out_lo,
  output logic [VW-1:0] in_lo,
  output logic [VW-1:0] in_hi,
  output logic [VW-1:0] out_hi
);
  import hps_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_lo <= VW'(DEF_OLO);
      in_lo  <= VW'(DEF_ILO);
      in_hi  <= VW'(DEF_IHI);
      out_hi <= VW'(DEF_OHI);
    end else if (we) begin
      case (int'(sel))
        SEL_OUT_LO: out_lo <= data;
        SEL_IN_LO:  in_lo  <= data;
        SEL_IN_HI:  in_hi  <= data;
        default:    out_hi <= data;
      endcase
    end
  end
endmodule

// File: rtl/hps_window.sv
module hps_window #(
  parameter int VW = 12
) (
  input  logic [VW-1:0] v,
  input  logic [VW-1:0] out_lo,
  input  logic [VW-1:0] in_lo,
  input  logic [VW-1:0] in_hi,
  input  logic [VW-1:0] out_hi,
  output logic          below_out,
  output logic          below_in,
  output logic          above_in,
  output logic          above_out
);
  assign below_out = v < out_lo;
  assign below_in  = v < in_lo;
  assign above_in  = v > in_hi;
  assign above_out = v > out_hi;
endmodule

// File: rtl/hps_min_tree.sv
module hps_min_tree #(
  parameter int NPH  = 4,
  parameter int IW   = 12,
  parameter int IDXW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic [NPH*IW-1:0] cur,
  output logic [IDXW-1:0]   min_idx
);
  localparam int LVL = (NPH > 1) ? $clog2(NPH) : 0;
  localparam int P   = 1 << LVL;

  logic [IW-1:0]   nv [1:2*P-1];
  logic [IDXW-1:0] ni [1:2*P-1];

  genvar k;
  generate
    for (k = 0; k < P; k++) begin : g_leaf
      if (k < NPH) begin : g_real
        assign nv[P+k] = cur[k*IW +: IW];
        assign ni[P+k] = IDXW'(k);
      end else begin : g_pad
        assign nv[P+k] = '1;
        assign ni[P+k] = '0;
      end
    end
    for (k = 1; k < P; k++) begin : g_node
      logic take_r;
      assign take_r = nv[2*k+1] < nv[2*k];
      assign nv[k]  = take_r ? nv[2*k+1] : nv[2*k];
      assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
    end
  endgenerate

  assign min_idx = ni[1];
endmodule

// File: rtl/hyst_phase_steer.sv
module hyst_phase_steer #(
  parameter int NPH     = 4,
  parameter int VW      = 12,
  parameter int IW      = 12,
  parameter int DEF_OLO = 2028,
  parameter int DEF_ILO = 2038,
  parameter int DEF_IHI = 2058,
  parameter int DEF_OHI = 2068
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [VW-1:0]     vout,
  input  logic [NPH*IW-1:0] iph,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [VW-1:0]     cfg_data,
  output logic [NPH-1:0]    hs_en,
  output logic [NPH-1:0]    ls_en
);
  import hps_pkg::*;

  localparam int IDXW = (NPH > 1) ? $clog2(NPH) : 1;

  logic [VW-1:0]   lim_olo, lim_ilo, lim_ihi, lim_ohi;
  logic            b_out, b_in, a_in, a_out;
  logic [IDXW-1:0] min_idx;
  mode_t           mode_q, mode_d;
  logic [IDXW-1:0] sel_q, sel_d;
  logic [NPH-1:0]  hs_d;

  hps_limits #(
    .VW(VW), .DEF_OLO(DEF_OLO), .DEF_ILO(DEF_ILO),
    .DEF_IHI(DEF_IHI), .DEF_OHI(DEF_OHI)
  ) u_lim (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .out_lo(lim_olo), .in_lo(lim_ilo), .in_hi(lim_ihi), .out_hi(lim_ohi)
  );

  hps_window #(.VW(VW)) u_win (
    .v(vout), .out_lo(lim_olo), .in_lo(lim_ilo), .in_hi(lim_ihi),
    .out_hi(lim_ohi), .below_out(b_out), .below_in(b_in),
    .above_in(a_in), .above_out(a_out)
  );

  hps_min_tree #(.NPH(NPH), .IW(IW), .IDXW(IDXW)) u_tree (
    .cur(iph), .min_idx(min_idx)
  );

  always_comb begin
    mode_d = mode_q;
    sel_d  = sel_q;
    if (smp_valid) begin
      if (b_out) begin
        mode_d = M_ALL;
      end else if (a_in || a_out) begin
        mode_d = M_OFF;
      end else if (b_in && mode_q != M_ONE) begin
        mode_d = M_ONE;
        sel_d  = min_idx;
      end
    end
  end

  always_comb begin
    hs_d = '0;
    case (mode_d)
      M_ALL:   hs_d = '1;
      M_ONE:   hs_d[sel_d] = 1'b1;
      default: hs_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_OFF;
      sel_q  <= '0;
      hs_en  <= '0;
      ls_en  <= '1;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      hs_en  <= hs_d;
      ls_en  <= ~hs_d;
    end
  end
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
  parameter int NPH = 4,
  parameter int VW  = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           smp_valid,
  input logic [VW-1:0]  vout,
  input logic [VW-1:0]  lim_olo,
  input logic [VW-1:0]  lim_ihi,
  input logic [NPH-1:0] hs_en,
  input logic [NPH-1:0] ls_en
);
  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen)
      assert_reset_off_R1: assert (hs_en == '0 && ls_en == '1)
        else $error("reset state wrong");
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_en & ls_en) == '0);

  assert_single_or_all_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hs_en) || (&hs_en));

  assert_outer_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && vout < lim_olo) |=> (&hs_en));

  assert_ceiling_off_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && vout >= lim_olo && vout > lim_ihi) |=> (hs_en == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(hs_en));

  assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && vout >= lim_olo && vout <= lim_ihi && $onehot(hs_en))
      |=> $stable(hs_en));
endmodule

bind hyst_phase_steer hps_checker #(.NPH(NPH), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .vout(vout),
  .lim_olo(lim_olo), .lim_ihi(lim_ihi), .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/tb_hyst_phase_steer.sv
`timescale 1ns/1ps
module tb_hyst_phase_steer;
  localparam int NPH = 4;
  localparam int VW  = 12;
  localparam int IW  = 12;
  localparam real TCK = 4.0;

  logic              clk = 0;
  logic              rst;
  logic              smp_valid;
  logic [VW-1:0]     vout;
  logic [NPH*IW-1:0] iph;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [VW-1:0]     cfg_data;
  logic [NPH-1:0]    hs_en, ls_en;

  int n_chk = 0;
  int n_bad = 0;

  int m_mode;
  int m_sel;
  int lim [4];

  always #(TCK/2) clk = ~clk;

  hyst_phase_steer dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .vout(vout), .iph(iph),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_hs();
    if (m_mode == 2) return 'hF;
    if (m_mode == 1) return 1 << m_sel;
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; smp_valid = 0; vout = 0; iph = '0;
    cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_mode = 0; m_sel = 0;
    lim[0] = 2028; lim[1] = 2038; lim[2] = 2058; lim[3] = 2068;
    #1;
    check("R1 hs after reset", int'(hs_en), 0);
    check("R1 ls after reset", int'(ls_en), 'hF);
  endtask

  task automatic step(input bit vld, input int v, input int c0, input int c1,
                      input int c2, input int c3, input bit we, input int sl,
                      input int dat, input string tag);
    int cur [4];
    int best;
    @(negedge clk);
    smp_valid = vld; vout = VW'(v);
    iph = {IW'(c3), IW'(c2), IW'(c1), IW'(c0)};
    cfg_we = we; cfg_sel = 2'(sl); cfg_data = VW'(dat);
    cur[0] = c0; cur[1] = c1; cur[2] = c2; cur[3] = c3;
    if (vld) begin
      if (v < lim[0]) m_mode = 2;
      else if (v > lim[2] || v > lim[3]) m_mode = 0;
      else if (v < lim[1] && m_mode != 1) begin
        best = 0;
        for (int k = 1; k < 4; k++) if (cur[k] < cur[best]) best = k;
        m_mode = 1; m_sel = best;
      end
    end
    if (we) lim[sl] = dat;
    @(posedge clk);
    #1;
    check(tag, int'(hs_en), exp_hs());
    check("R8 ls complement", int'(ls_en), (~exp_hs()) & 'hF);
  endtask

  initial begin
    #(TCK * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    do_reset();
    step(1, 2045, 5, 5, 5, 5, 0, 0, 0, "R4 in band stays off");
    step(1, 2038, 5, 5, 5, 5, 0, 0, 0, "R2 equal to inner floor no pulse");
    step(1, 2037, 50, 30, 40, 60, 0, 0, 0, "R2 pulse on min phase 1");
    step(1, 2040, 50, 90, 10, 60, 0, 0, 0, "R4 held in band");
    step(1, 2030, 50, 90, 10, 60, 0, 0, 0, "R4 held below floor");
    step(1, 2058, 50, 90, 10, 60, 0, 0, 0, "R4 held at ceiling");
    step(0, 3000, 1, 2, 3, 4, 0, 0, 0, "R9 no strobe high v");
    step(0, 100, 1, 2, 3, 4, 0, 0, 0, "R9 no strobe low v");
    step(1, 2059, 50, 90, 10, 60, 0, 0, 0, "R5 above ceiling off");
    step(1, 2037, 20, 20, 20, 20, 0, 0, 0, "R3 full tie picks phase 0");
    step(1, 2059, 20, 20, 20, 20, 0, 0, 0, "R5 off again");
    step(1, 2037, 30, 10, 10, 30, 0, 0, 0, "R3 tie across pairs picks 1");
    step(1, 2059, 0, 0, 0, 0, 0, 0, 0, "R5 off");
    step(1, 2037, 30, 30, 9, 9, 0, 0, 0, "R3 right pair tie picks 2");
    step(1, 2027, 30, 30, 9, 9, 0, 0, 0, "R6 below outer floor all on");
    step(1, 2045, 1, 2, 3, 4, 0, 0, 0, "R11 all on held in band");
    step(1, 2028, 7, 6, 5, 8, 0, 0, 0, "R11 exit to single pulse");
    step(1, 2027, 7, 6, 5, 8, 0, 0, 0, "R6 override pulse");
    step(1, 2069, 7, 6, 5, 8, 0, 0, 0, "R7 above outer ceiling off");
    step(1, 2028, 7, 6, 5, 4, 0, 0, 0, "R2 at outer floor pulse on 3");
    step(1, 2069, 7, 6, 5, 4, 0, 0, 0, "R7 off");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1900, "R10 write outer floor");
    step(1, 2010, 4, 3, 2, 1, 1, 1, 2000, "R10 old floor used same cycle");
    step(1, 2059, 4, 3, 2, 1, 0, 0, 0, "R5 off");
    step(1, 2010, 4, 3, 2, 1, 0, 0, 0, "R10 new inner floor no pulse");
    step(1, 1999, 4, 3, 2, 1, 0, 0, 0, "R10 below new floor pulse");
    step(1, 2030, 4, 3, 2, 1, 1, 2, 2020, "R10 write ceiling");
    step(1, 2021, 4, 3, 2, 1, 0, 0, 0, "R10 above new ceiling off");
    step(1, 1899, 4, 3, 2, 1, 0, 0, 0, "R6 below new outer floor");
    step(0, 0, 0, 0, 0, 0, 1, 0, 2028, "R10 restore");
    step(0, 0, 0, 0, 0, 0, 1, 1, 2038, "R10 restore");
    step(0, 0, 0, 0, 0, 0, 1, 2, 2058, "R10 restore");
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 3) != 0, 2020 + $urandom_range(0, 55),
           $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 15),
           0, 0, 0, "R2 R4 R5 R6 R7 random");
    end
    do_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule